// File: doc/BRIEF.md
# AXI3 Write-Data De-interleaver

This block converts an AXI3 write port, where the data beats of several open bursts may arrive mixed together and are told apart by a write-data ID, into an AXI4-style write port that has no data ID. On the downstream side every burst leaves as an unbroken run of beats, and the bursts leave in the order in which their addresses were accepted. Write responses are passed by surrounding logic and are not handled here.

Each accepted address claims one of `DEPTH` slots, where `DEPTH` is the interleave depth that the port declares. A slot keeps the address fields, the ID and a buffer of up to `MAX_BEATS` beats of data, strobe and last flag. Upstream beats are steered by their ID into the matching slot. The slot of the oldest outstanding address drains downstream once its address has left, and the slot is released when its last beat has been sent. Addresses go downstream from an order queue. The downstream ID matches the upstream ID so that responses can be routed back. The length field is widened to 8 bits.

Top module: `wr_deinterleaver`

## Requirements
- R1: After reset, `s_awready` is 1, and `m_awvalid` and `m_wvalid` are 0.
- R2: A transaction is open from the cycle its address is accepted upstream until the cycle its last beat is accepted downstream. `s_awready` is 1 exactly when fewer than `DEPTH` transactions are open.
- R3: Downstream addresses leave in upstream acceptance order. They keep the ID, address, size and burst type unchanged, and `m_awlen` carries the 4-bit upstream length zero-extended to 8 bits.
- R4: Each transaction of length L leaves as L+1 consecutive downstream beats. `m_wlast` is 1 only on the final beat, and no other transaction's beat falls between them.
- R5: Upstream beats of transactions with different IDs may be mixed in any way that keeps the first beats in address order. Every beat still arrives downstream with its data and strobe unchanged, at its place in the address order.
- R6: When several open transactions share one ID, a beat with that ID belongs to the oldest of them whose last beat has not yet been received.
- R7: An upstream beat whose ID matches no open transaction that is still receiving data is held off with `s_wready` 0. It is taken once an address with that ID has been accepted.
- R8: A transaction's data is never offered downstream before its address has been transferred downstream.
- R9: While `m_awvalid` or `m_wvalid` is 1 and the matching ready is 0, the valid stays 1 and the payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | ID_W | Upstream address ID |
| s_awaddr | input | ADDR_W | Upstream start address |
| s_awlen | input | 4 | Upstream beats minus one |
| s_awsize | input | 3 | Upstream beat size |
| s_awburst | input | 2 | Upstream burst type |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wid | input | ID_W | Upstream data ID |
| s_wdata | input | DATA_W | Upstream data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| m_awid | output | ID_W | Downstream address ID |
| m_awaddr | output | ADDR_W | Downstream start address |
| m_awlen | output | 8 | Downstream beats minus one |
| m_awsize | output | 3 | Downstream beat size |
| m_awburst | output | 2 | Downstream burst type |
| m_awvalid | output | 1 | Downstream address valid |
| m_awready | input | 1 | Downstream address ready |
| m_wdata | output | DATA_W | Downstream data |
| m_wstrb | output | DATA_W/8 | Downstream byte strobes |
| m_wlast | output | 1 | Downstream last beat |
| m_wvalid | output | 1 | Downstream data valid |
| m_wready | input | 1 | Downstream data ready |

## Verification
The sharpest collision comes when the head slot sends its last beat downstream in the same cycle as a new address is accepted upstream. In that cycle one slot is released and another is claimed, and the occupancy must not move. A related case is a beat being written into a slot while another slot drains. The bench provokes both with random ready patterns on both sides and a stalled start that fills every slot. Every cycle it compares `s_awready` with its own count of open transactions, and it checks every downstream beat against the transaction the address order says must be current.

// File: rtl/wr_deinterleaver.sv
module wr_deinterleaver #(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int MAX_BEATS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [3:0]          s_awlen,
  input  logic [2:0]          s_awsize,
  input  logic [1:0]          s_awburst,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_wid,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready
);
  localparam int STRB_W = DATA_W / 8;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BPTR_W = $clog2(MAX_BEATS);
  localparam int CNT_W  = BPTR_W + 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int MEM_AW = SLOT_W + BPTR_W;
  localparam int WORD_W = DATA_W + STRB_W + 1;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic [DEPTH-1:0]  act, done;
  logic [ID_W-1:0]   sid   [DEPTH];
  logic [ADDR_W-1:0] sadr  [DEPTH];
  logic [3:0]        slen  [DEPTH];
  logic [2:0]        ssz   [DEPTH];
  logic [1:0]        sbr   [DEPTH];
  logic [BPTR_W-1:0] wp    [DEPTH];
  logic [BPTR_W-1:0] rp    [DEPTH];
  logic [CNT_W-1:0]  cnt   [DEPTH];
  logic [SLOT_W-1:0] ord   [DEPTH];
  logic [SLOT_W-1:0] hd, tl, ap;
  logic [OCC_W-1:0]  occ, apend;
  logic [WORD_W-1:0] mem   [2**MEM_AW];

  logic              fr_ok, mt_ok;
  logic [SLOT_W-1:0] fr, mt, hs, as;
  logic              head_ok;
  logic              aw_in, w_in, aw_out, w_out, pop;

  always_comb begin
    fr_ok = 1'b0;
    fr    = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!act[i]) begin
        fr_ok = 1'b1;
        fr    = SLOT_W'(i);
      end
  end

  always_comb begin
    logic [SLOT_W-1:0] pos;
    logic [SLOT_W-1:0] cand;
    mt_ok = 1'b0;
    mt    = '0;
    pos   = hd;
    for (int k = 0; k < DEPTH; k++) begin
      cand = ord[pos];
      if (!mt_ok && k < int'(occ) && !done[cand] && sid[cand] == s_wid) begin
        mt_ok = 1'b1;
        mt    = cand;
      end
      pos = nxt(pos);
    end
  end

  assign hs      = ord[hd];
  assign as      = ord[ap];
  assign head_ok = (occ != '0) && (apend < occ);

  assign s_awready = fr_ok;
  assign s_wready  = mt_ok && (cnt[mt] != CNT_W'(MAX_BEATS));

  assign m_awvalid = (apend != '0);
  assign m_awid    = sid[as];
  assign m_awaddr  = sadr[as];
  assign m_awlen   = {4'b0000, slen[as]};
  assign m_awsize  = ssz[as];
  assign m_awburst = sbr[as];

  assign m_wvalid = head_ok && (cnt[hs] != '0);
  assign {m_wlast, m_wstrb, m_wdata} = mem[{hs, rp[hs]}];

  assign aw_in  = s_awvalid && s_awready;
  assign w_in   = s_wvalid && s_wready;
  assign aw_out = m_awvalid && m_awready;
  assign w_out  = m_wvalid && m_wready;
  assign pop    = w_out && m_wlast;

  always_ff @(posedge clk)
    if (w_in) mem[{mt, wp[mt]}] <= {s_wlast, s_wstrb, s_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= '0;
      done  <= '0;
      hd    <= '0;
      tl    <= '0;
      ap    <= '0;
      occ   <= '0;
      apend <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        sid[i]  <= '0;
        sadr[i] <= '0;
        slen[i] <= '0;
        ssz[i]  <= '0;
        sbr[i]  <= '0;
        wp[i]   <= '0;
        rp[i]   <= '0;
        cnt[i]  <= '0;
        ord[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (aw_in && fr == SLOT_W'(i)) begin
          act[i]  <= 1'b1;
          done[i] <= 1'b0;
          sid[i]  <= s_awid;
          sadr[i] <= s_awaddr;
          slen[i] <= s_awlen;
          ssz[i]  <= s_awsize;
          sbr[i]  <= s_awburst;
          wp[i]   <= '0;
          rp[i]   <= '0;
          cnt[i]  <= '0;
        end else begin
          if (w_in && mt == SLOT_W'(i)) begin
            wp[i] <= wp[i] + 1'b1;
            if (s_wlast) done[i] <= 1'b1;
          end
          if (w_out && hs == SLOT_W'(i)) begin
            rp[i] <= rp[i] + 1'b1;
            if (m_wlast) act[i] <= 1'b0;
          end
          cnt[i] <= cnt[i] + CNT_W'(w_in && mt == SLOT_W'(i))
                           - CNT_W'(w_out && hs == SLOT_W'(i));
        end
      end
      if (aw_in) begin
        ord[tl] <= fr;
        tl      <= nxt(tl);
      end
      if (pop)    hd <= nxt(hd);
      if (aw_out) ap <= nxt(ap);
      occ   <= occ + OCC_W'(aw_in) - OCC_W'(pop);
      apend <= apend + OCC_W'(aw_in) - OCC_W'(aw_out);
    end
  end
endmodule

// File: rtl/wr_deinterleaver_chk.sv
module wr_deinterleaver_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [31:0]       m_awaddr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready
);
  logic [7:0] open_n, dn_pend;
  logic       up_aw, dn_aw, dn_last;

  assign up_aw   = s_awvalid && s_awready;
  assign dn_aw   = m_awvalid && m_awready;
  assign dn_last = m_wvalid && m_wready && m_wlast;

  always_ff @(posedge clk)
    if (!rst_n) begin
      open_n  <= '0;
      dn_pend <= '0;
    end else begin
      open_n  <= open_n + 8'(up_aw) - 8'(dn_last);
      dn_pend <= dn_pend + 8'(dn_aw) - 8'(dn_last);
    end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) open_n <= 8'(DEPTH)); // R2
  AST_FULL_BLOCKS_AW: assert property (@(posedge clk) disable iff (!rst_n) (open_n == 8'(DEPTH)) |-> !s_awready); // R2
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n) m_wvalid |-> (dn_pend != 8'd0)); // R8
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast))); // R9
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr))); // R9
endmodule

bind wr_deinterleaver wr_deinterleaver_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(32'(m_awaddr)),
  .m_wdata(m_wdata), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready)
);

// File: tb/wr_deinterleaver_tb_top.sv
`timescale 1ns/1ps
module wr_deinterleaver_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  s_awid = '0, s_wid = '0, m_awid;
  logic [31:0] s_awaddr = '0, m_awaddr, s_wdata = '0, m_wdata;
  logic [3:0]  s_awlen = '0, s_wstrb = '0, m_wstrb;
  logic [2:0]  s_awsize = '0, m_awsize;
  logic [1:0]  s_awburst = '0, m_awburst;
  logic [7:0]  m_awlen;
  logic        s_awvalid = 1'b0, s_awready, s_wlast = 1'b0, s_wvalid = 1'b0, s_wready;
  logic        m_awvalid, m_awready = 1'b0, m_wlast, m_wvalid, m_wready = 1'b0;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  wr_deinterleaver dut_i (.*);

  int          t_id   [64];
  int          t_len  [64];
  logic [31:0] t_addr [64];
  logic [31:0] t_dat  [64][16];
  logic [3:0]  t_stb  [64][16];
  int          wsent  [64];

  function automatic logic [31:0] beat_word(int j, int b);
    return t_dat[j][b];
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_scn(input string tag, input int n, input int id_span,
                         input int len_mode, input int stall);
    int up_aw = 0, dn_aw = 0, dn_t = 0, dn_b = 0, cyc = 0, sel = 0;
    bit aw_v = 0, w_v = 0, prev_stall = 0;
    logic [31:0] prev_data = '0;
    for (int j = 0; j < n; j++) begin
      t_id[j]   = int'($urandom % id_span);
      t_len[j]  = (len_mode == 1) ? 0 : (len_mode == 2) ? 15 : int'($urandom % 16);
      t_addr[j] = $urandom & 32'hFFFF_FFFC;
      wsent[j]  = 0;
      for (int b = 0; b < 16; b++) begin
        t_dat[j][b] = $urandom;
        t_stb[j][b] = 4'($urandom);
      end
    end
    while (dn_t < n && cyc < 20000) begin
      bit aw_hs, w_hs, maw_hs, mw_hs;
      @(negedge clk);
      if (!aw_v && up_aw < n && ($urandom % 4) != 0) aw_v = 1;
      s_awvalid = aw_v;
      if (up_aw < n) begin
        s_awid    = 4'(t_id[up_aw]);
        s_awaddr  = t_addr[up_aw];
        s_awlen   = 4'(t_len[up_aw]);
        s_awsize  = 3'd2;
        s_awburst = 2'd1;
      end
      if (!w_v) begin
        int elig [64];
        int ne = 0;
        int first_un = n;
        for (int j = 0; j < n; j++)
          if (wsent[j] == 0) begin first_un = j; break; end
        for (int j = 0; j < up_aw; j++) begin
          bit ok = (wsent[j] <= t_len[j]) && (wsent[j] > 0 || j == first_un);
          for (int k = 0; k < j; k++)
            if (t_id[k] == t_id[j] && wsent[k] <= t_len[k]) ok = 0;
          if (ok) begin elig[ne] = j; ne++; end
        end
        if (ne > 0 && ($urandom % 4) != 0) begin
          sel = elig[$urandom % ne];
          w_v = 1;
        end
      end
      s_wvalid = w_v;
      s_wid    = 4'(t_id[sel]);
      s_wdata  = beat_word(sel, wsent[sel] % 16);
      s_wstrb  = t_stb[sel][wsent[sel] % 16];
      s_wlast  = (wsent[sel] == t_len[sel]);
      m_awready = (cyc >= stall) && (($urandom % 4) != 0);
      m_wready  = (cyc >= stall) && (($urandom % 4) != 0);
      #1;
      chk("R2", 64'(s_awready), 64'((up_aw - dn_t) < DEPTH));
      if (prev_stall) begin
        chk("R9", {31'd0, m_wvalid, m_wdata}, {31'd1, prev_data});
      end
      if (m_wvalid) chk("R8", 64'(dn_aw > dn_t), 64'd1);
      aw_hs  = s_awvalid && s_awready;
      w_hs   = s_wvalid && s_wready;
      maw_hs = m_awvalid && m_awready;
      mw_hs  = m_wvalid && m_wready;
      if (maw_hs) begin
        chk("R3", {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst},
            {4'(t_id[dn_aw]), t_addr[dn_aw], 8'(t_len[dn_aw]), 3'd2, 2'd1});
      end
      if (mw_hs) begin
        chk(tag, {m_wstrb, m_wdata}, {t_stb[dn_t][dn_b], t_dat[dn_t][dn_b]});
        chk("R4", 64'(m_wlast), 64'(dn_b == t_len[dn_t]));
      end
      prev_stall = m_wvalid && !m_wready;
      prev_data  = m_wdata;
      @(posedge clk);
      if (aw_hs) begin up_aw++; aw_v = 0; end
      if (w_hs) begin wsent[sel]++; w_v = 0; end
      if (maw_hs) dn_aw++;
      if (mw_hs) begin
        if (dn_b == t_len[dn_t]) begin dn_t++; dn_b = 0; end
        else dn_b++;
      end
      cyc++;
    end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; m_awready = 0; m_wready = 0;
    chk("R4", 64'(dn_t), 64'(n));
  endtask

  // R7: a data beat with no matching address is held until the address arrives
  task automatic unmatched_id();
    @(negedge clk);
    m_awready = 1; m_wready = 1;
    s_wvalid = 1; s_wid = 4'd9; s_wdata = 32'hCAFE_0009; s_wstrb = 4'hF; s_wlast = 1;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R7", 64'(s_wready), 64'd0);
      @(negedge clk);
    end
    s_awvalid = 1; s_awid = 4'd9; s_awaddr = 32'h100; s_awlen = 0; s_awsize = 3'd2; s_awburst = 2'd1;
    #1 chk("R7", 64'(s_awready), 64'd1);
    @(negedge clk);
    s_awvalid = 0;
    #1 chk("R7", 64'(s_wready), 64'd1);
    @(negedge clk);
    s_wvalid = 0;
    for (int i = 0; i < 10 && !m_wvalid; i++) @(negedge clk);
    #1 chk("R7", {m_wvalid, m_wlast, m_wdata}, {1'b1, 1'b1, 32'hCAFE_0009});
    @(negedge clk);
    m_awready = 0; m_wready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4: watchdog got running exp finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(posedge clk);
    #1 chk("R1", {s_awready, m_awvalid, m_wvalid}, 3'b100);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1", {s_awready, m_awvalid, m_wvalid}, 3'b100);
    unmatched_id();
    run_scn("R5", 40, 4, 0, 0);   // mixed IDs, interleaved beats
    run_scn("R6", 12, 1, 0, 0);   // one shared ID
    run_scn("R5", 10, 3, 0, 40);  // downstream stalled: all slots fill (R2)
    run_scn("R5", 20, 4, 1, 0);   // single-beat bursts
    run_scn("R6", 8, 2, 2, 0);    // sixteen-beat bursts fill a slot buffer
    run_scn("R5", 60, 4, 0, 0);
    summary();
  end
endmodule